// File: doc/BRIEF.md
# Graphics Port Grant and Status Arbiter

This block sits on the target side of a point-to-point graphics port that has one master. Each cycle in which no grant is outstanding, it looks at the work the core has pending and at two lines from the master. It then picks the single most urgent action and tells the master about it. The choice goes out as an active-low grant together with a 3-bit status code that names the action. The same choice goes to the local data-transfer logic as a one-hot select vector.

The arbiter registers the grant, status and select one clock edge after the decision. It holds all three without change until the data-transfer logic pulses `xfer_done`. On the edge after that pulse the grant is withdrawn. The arbiter then needs at least one idle cycle before it makes the next decision.

The master's read-buffer-full line (`buf_full_n`, low when the buffer is full) can hold back low-priority read returns. It is looked at only in the decision cycle. Once a transfer has been granted, the line has no effect until the next decision. All pins are plain control and status levels. The block has no streaming interface, so it has no valid/ready back-pressure. The only flow control is `buf_full_n` toward the master and `xfer_done` from the local data path.

Top module: `gport_grant_arb`

## Requirements
- R1: While `rst_n` is low, and after reset until something becomes eligible, `gnt_n` is 1 and `sel` is 0.
- R2: A pending high-priority read return (`hp_rd_rdy`) wins over every other source and is granted with status 3'b001 and `sel` bit 0.
- R3: With no high-priority read pending, a high-priority write-data request (`hp_wr_need`) is granted with status 3'b011 and `sel` bit 1.
- R4: A low-priority read return (`lp_rd_rdy`) is granted with status 3'b000 and `sel` bit 2 only if `buf_full_n` is 1 in the decision cycle. While `buf_full_n` is 0 it is skipped and lower sources may win.
- R5: A low-priority write-data request (`lp_wr_need`) is granted with status 3'b010 and `sel` bit 3 when no higher source is eligible.
- R6: Permission to start a transaction (status 3'b111, `sel` bit 4) is given only when `new_txn_ok` is 1, `req_n` is 0 and nothing else is eligible. Without `req_n` low, `new_txn_ok` alone produces no grant.
- R7: `status` never carries the reserved codes 3'b100, 3'b101 or 3'b110.
- R8: The grant appears on the clock edge after the decision cycle. Grant, status and select stay unchanged while `xfer_done` is 0, even if the pending inputs change. The grant is removed on the edge after `xfer_done` is 1, and `gnt_n` stays high for at least one cycle before the next grant.
- R9: Changes on `buf_full_n` while a grant is held do not alter the grant, status or select.
- R10: `sel` is one-hot while `gnt_n` is 0 and all-zero while `gnt_n` is 1.
- R11: When no source is eligible, `gnt_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Master request, active low |
| buf_full_n | input | 1 | Master read buffer full, active low (0 = full) |
| hp_rd_rdy | input | 1 | Core has high-priority read data to return |
| hp_wr_need | input | 1 | Core needs high-priority write data |
| lp_rd_rdy | input | 1 | Core has low-priority read data to return |
| lp_wr_need | input | 1 | Core needs low-priority write data |
| new_txn_ok | input | 1 | Core can accept a new transaction |
| xfer_done | input | 1 | Data-transfer logic finished the selected action |
| gnt_n | output | 1 | Grant to the master, active low |
| status | output | 3 | Action code, valid while `gnt_n` is 0 |
| sel | output | 5 | One-hot selected action for the data-transfer logic |

## Verification
Each source is first driven on its own, which pins each status code and select bit to its source. The sources are then driven in overlapping pairs, which shows the fixed order rather than just the presence of a request. The low-priority read is tried with the buffer full, both alone and next to a low-priority write. This tells a blocked read apart from a read that is simply absent. `new_txn_ok` is tried with and without `req_n`. Inputs, including `buf_full_n`, are toggled during a held grant to separate sampling at the decision point from continuous tracking. A higher source is left pending across a release, which exposes the idle cycle between grants.

// File: rtl/gport_arb_pkg.sv
package gport_arb_pkg;
  localparam int STAT_W = 3;
  localparam int N_ACT  = 5;

  // Action slots in fixed priority order (index 0 wins).
  localparam int A_HP_RD = 0;
  localparam int A_HP_WR = 1;
  localparam int A_LP_RD = 2;
  localparam int A_LP_WR = 3;
  localparam int A_START = 4;

  typedef enum logic [STAT_W-1:0] {
    ST_LP_RD = 3'b000,
    ST_HP_RD = 3'b001,
    ST_LP_WR = 3'b010,
    ST_HP_WR = 3'b011,
    ST_START = 3'b111
  } stat_e;

  typedef enum logic {S_IDLE, S_HOLD} arb_state_e;

  function automatic logic [STAT_W-1:0] act_code(input int idx);
    case (idx)
      A_HP_RD: act_code = ST_HP_RD;
      A_HP_WR: act_code = ST_HP_WR;
      A_LP_RD: act_code = ST_LP_RD;
      A_LP_WR: act_code = ST_LP_WR;
      default: act_code = ST_START;
    endcase
  endfunction
endpackage

// File: rtl/gport_arb_eligible.sv
module gport_arb_eligible
  import gport_arb_pkg::*;
(
  input  logic             req_n,
  input  logic             buf_full_n,
  input  logic             hp_rd_rdy,
  input  logic             hp_wr_need,
  input  logic             lp_rd_rdy,
  input  logic             lp_wr_need,
  input  logic             new_txn_ok,
  output logic [N_ACT-1:0] elig
);
  // Low-priority reads are held back while the master's buffer is full;
  // a new transaction needs both the core's permission and a request.
  always_comb begin
    elig          = '0;
    elig[A_HP_RD] = hp_rd_rdy;
    elig[A_HP_WR] = hp_wr_need;
    elig[A_LP_RD] = lp_rd_rdy & buf_full_n;
    elig[A_LP_WR] = lp_wr_need;
    elig[A_START] = new_txn_ok & ~req_n;
  end
endmodule

// File: rtl/gport_arb_prio.sv
module gport_arb_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  logic [N:0] taken;
  assign taken[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_slot
    assign pick[i]    = req[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req[i];
  end
endmodule

// File: rtl/gport_arb_encode.sv
module gport_arb_encode
  import gport_arb_pkg::*;
(
  input  logic [N_ACT-1:0]  onehot,
  output logic [STAT_W-1:0] code
);
  always_comb begin
    code = '0;
    for (int i = 0; i < N_ACT; i++) begin
      if (onehot[i]) code = code | act_code(i);
    end
  end
endmodule

// File: rtl/gport_grant_arb.sv
module gport_grant_arb
  import gport_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_n,
  input  logic              buf_full_n,
  input  logic              hp_rd_rdy,
  input  logic              hp_wr_need,
  input  logic              lp_rd_rdy,
  input  logic              lp_wr_need,
  input  logic              new_txn_ok,
  input  logic              xfer_done,
  output logic              gnt_n,
  output logic [STAT_W-1:0] status,
  output logic [N_ACT-1:0]  sel
);
  logic [N_ACT-1:0]  elig;
  logic [N_ACT-1:0]  pick;
  logic [STAT_W-1:0] pick_code;

  arb_state_e        state_q;
  logic [STAT_W-1:0] stat_q;
  logic [N_ACT-1:0]  sel_q;

  gport_arb_eligible u_elig (
    .req_n      (req_n),
    .buf_full_n (buf_full_n),
    .hp_rd_rdy  (hp_rd_rdy),
    .hp_wr_need (hp_wr_need),
    .lp_rd_rdy  (lp_rd_rdy),
    .lp_wr_need (lp_wr_need),
    .new_txn_ok (new_txn_ok),
    .elig       (elig)
  );

  gport_arb_prio #(.N(N_ACT)) u_prio (
    .req  (elig),
    .pick (pick)
  );

  gport_arb_encode u_enc (
    .onehot (pick),
    .code   (pick_code)
  );

  // Decisions are taken only in S_IDLE; in S_HOLD every input except
  // xfer_done is ignored, so buf_full_n counts only at the decision point.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      stat_q  <= ST_LP_RD;
      sel_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (|pick) begin
            state_q <= S_HOLD;
            stat_q  <= pick_code;
            sel_q   <= pick;
          end
        end
        default: begin
          if (xfer_done) begin
            state_q <= S_IDLE;
            sel_q   <= '0;
          end
        end
      endcase
    end
  end

  assign gnt_n  = (state_q != S_HOLD);
  assign status = stat_q;
  assign sel    = sel_q;
endmodule

// File: rtl/gport_arb_chk.sv
module gport_arb_chk
  import gport_arb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_n,
  input logic              buf_full_n,
  input logic              hp_rd_rdy,
  input logic              hp_wr_need,
  input logic              xfer_done,
  input logic              gnt_n,
  input logic [STAT_W-1:0] status,
  input logic [N_ACT-1:0]  sel
);
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> gnt_n);

  assert_hp_read_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gnt_n) && $past(hp_rd_rdy)) |-> status == 3'b001);

  assert_hp_write_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gnt_n) && !$past(hp_rd_rdy) && $past(hp_wr_need)) |-> status == 3'b011);

  assert_no_lp_read_when_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gnt_n) && status == 3'b000) |-> $past(buf_full_n));

  assert_start_needs_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gnt_n) && status == 3'b111) |-> !$past(req_n));

  assert_no_reserved_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(status inside {3'b100, 3'b101, 3'b110}));

  assert_hold_until_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_n && !xfer_done) |=> (!gnt_n && $stable(status) && $stable(sel)));

  assert_release_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_n && xfer_done) |=> gnt_n);

  assert_sel_matches_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_n ? (sel == '0) : $onehot(sel));
endmodule

bind gport_grant_arb gport_arb_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_n      (req_n),
  .buf_full_n (buf_full_n),
  .hp_rd_rdy  (hp_rd_rdy),
  .hp_wr_need (hp_wr_need),
  .xfer_done  (xfer_done),
  .gnt_n      (gnt_n),
  .status     (status),
  .sel        (sel)
);

// File: tb/sim_gport_grant_arb.sv
module sim_gport_grant_arb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_n, buf_full_n;
  logic       hp_rd_rdy, hp_wr_need, lp_rd_rdy, lp_wr_need, new_txn_ok;
  logic       xfer_done;
  logic       gnt_n;
  logic [2:0] status;
  logic [4:0] sel;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #4 clk = ~clk;

  gport_grant_arb u0 (
    .clk(clk), .rst_n(rst_n), .req_n(req_n), .buf_full_n(buf_full_n),
    .hp_rd_rdy(hp_rd_rdy), .hp_wr_need(hp_wr_need), .lp_rd_rdy(lp_rd_rdy),
    .lp_wr_need(lp_wr_need), .new_txn_ok(new_txn_ok), .xfer_done(xfer_done),
    .gnt_n(gnt_n), .status(status), .sel(sel)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic hr, input logic hw, input logic lr,
                       input logic lw, input logic nt, input logic rq_n,
                       input logic bf_n);
    hp_rd_rdy = hr; hp_wr_need = hw; lp_rd_rdy = lr; lp_wr_need = lw;
    new_txn_ok = nt; req_n = rq_n; buf_full_n = bf_n;
  endtask

  // Checks a granted action, then releases it and checks the release (R8, R10).
  task automatic expect_grant(input string tag, input int code, input int onehot);
    @(negedge clk);
    check({tag, " gnt_n"}, gnt_n, 0);
    check({tag, " status"}, status, code);
    check({tag, " sel"}, sel, onehot);
    check({tag, " R7 not reserved"}, int'(status inside {3'b100, 3'b101, 3'b110}), 0);
    drive(0, 0, 0, 0, 0, 1, 1);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check({tag, " R8 release"}, gnt_n, 1);
    check({tag, " R10 sel clear"}, sel, 0);
  endtask

  task automatic expect_none(input string tag);
    repeat (3) @(negedge clk);
    check({tag, " gnt_n"}, gnt_n, 1);
    check({tag, " sel"}, sel, 0);
    drive(0, 0, 0, 0, 0, 1, 1);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset gnt_n", gnt_n, 1);
    check("R1 reset sel", sel, 0);
    @(negedge clk); @(negedge clk);
    check("R11 idle no grant", gnt_n, 1);
  endtask

  task automatic t_single;
    drive(1, 0, 0, 0, 0, 1, 1); expect_grant("R2 hp read alone", 1, 5'b00001);
    drive(0, 1, 0, 0, 0, 1, 1); expect_grant("R3 hp write alone", 3, 5'b00010);
    drive(0, 0, 1, 0, 0, 1, 1); expect_grant("R4 lp read alone", 0, 5'b00100);
    drive(0, 0, 0, 1, 0, 1, 1); expect_grant("R5 lp write alone", 2, 5'b01000);
    drive(0, 0, 0, 0, 1, 0, 1); expect_grant("R6 start", 7, 5'b10000);
  endtask

  task automatic t_priority;
    drive(1, 1, 1, 1, 1, 0, 1); expect_grant("R2 all pending", 1, 5'b00001);
    drive(0, 1, 1, 1, 1, 0, 1); expect_grant("R3 over low", 3, 5'b00010);
    drive(0, 0, 1, 1, 1, 0, 1); expect_grant("R4 over lp write", 0, 5'b00100);
    drive(0, 0, 0, 1, 1, 0, 1); expect_grant("R5 over start", 2, 5'b01000);
  endtask

  task automatic t_buffer_full;
    drive(0, 0, 1, 0, 0, 1, 0); expect_none("R4 lp read blocked");
    drive(0, 0, 1, 1, 0, 1, 0); expect_grant("R4 blocked lp write wins", 2, 5'b01000);
    drive(0, 1, 1, 0, 0, 1, 0); expect_grant("R4 full no effect on hp", 3, 5'b00010);
  endtask

  task automatic t_start_gate;
    drive(0, 0, 0, 0, 1, 1, 1); expect_none("R6 no request no start");
    drive(0, 0, 0, 0, 0, 0, 1); expect_none("R11 request without permission");
  endtask

  task automatic t_hold;
    drive(0, 0, 1, 0, 0, 1, 1);
    @(negedge clk);
    check("R8 lp read granted", gnt_n, 0);
    drive(1, 1, 0, 0, 0, 1, 0);
    repeat (3) @(negedge clk);
    check("R9 hold gnt", gnt_n, 0);
    check("R9 hold status", status, 0);
    check("R8 hold sel", sel, 5'b00100);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check("R8 idle gap", gnt_n, 1);
    @(negedge clk);
    check("R8 next grant hp read", status, 1);
    check("R8 next grant gnt", gnt_n, 0);
    drive(0, 0, 0, 0, 0, 1, 1);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    check("R8 final release", gnt_n, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    xfer_done = 1'b0;
    drive(0, 0, 0, 0, 0, 1, 1);
    repeat (3) @(negedge clk);
    check("R1 in reset", gnt_n, 1);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_priority();
    t_buffer_full();
    t_start_gate();
    t_hold();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule